// File: doc/BRIEF.md
# I2C Addressed Slave Responder

This block is the target half of a register-driven I2C controller. It watches the shared SCL and SDA lines through a short synchronizer. In the first byte after every START it compares the seven upper bits against a programmed own address. When the address matches and the acknowledge-enable input is high, it answers with an ACK. The last bit of that byte selects the direction. A 0 makes the block a receiver of bytes from the bus master. A 1 makes it a sender of bytes to the master.

Each bus event is posted as an 8-bit status code on an event stream (`evt_valid`, `evt_code`, `rx_byte`). While an event is pending and SCL is low, the block holds SCL low, so the bus master waits while the host catches up. The host accepts an event by raising `evt_ready` for one cycle. In transmit mode, that same handshake samples `tx_byte` as the next byte to send. There is no other back-pressure: `evt_valid` stays high, with a stable code and data, until it is accepted. A newer event overwrites one that has not been accepted.

When the master side of the controller loses arbitration and the block is then addressed, a distinct code reports the switch into slave operation. Line outputs are open-drain pulls: a 1 on a pull output means "drive the line low".

Top module: `i2cs_responder`

## Requirements
- R1: After reset, `evt_valid` is 0, `evt_code` is 0xF8, and neither line is pulled.
- R2: A first byte whose bits [7:1] equal `own_addr[7:1]`, with bit 0 equal to 0 and `ack_enable` high, is ACKed (SDA pulled in the 9th clock). After the 9th SCL fall the block posts code 0x60, and `rx_byte` holds the address byte.
- R3: The same match with bit 0 equal to 1 is ACKed and posts 0xA8. The `tx_byte` value sampled at the handshake is then sent MSB first, and every following byte is loaded in the same way.
- R4: When the address does not match, or `ack_enable` is low, the block sends no ACK and posts no event. It also leaves SDA untouched for the rest of that transfer, until the next START.
- R5: For a received data byte, `ack_enable` is sampled at the 8th SCL fall. If it is high, the block ACKs and posts 0x80. If it is low, the block NACKs, posts 0x88, and becomes not-addressed. `rx_byte` holds the byte in both cases.
- R6: In transmit, a master ACK posts 0xB8 and the next byte is loaded. A master NACK posts 0xC0, after which the block releases SDA and posts nothing further.
- R7: If `ack_enable` is low at the handshake that loads a transmit byte, that byte is still sent. A master ACK of it then posts 0xC8, and any further bytes the master clocks read as 0xFF.
- R8: A STOP or a repeated START while the block is addressed as a receiver posts 0xA0. After a repeated START, the following address byte is recognised as usual.
- R9: An `arb_lost` pulse seen after the last STOP and before the address ACK changes the address code to 0x68 for a write and to 0xB0 for a read.
- R10: While an event is pending and SCL is low, SCL is pulled. The pull is released after the handshake, and no event is pending in the cycle after a handshake. With no pending event, `evt_code` reads 0xF8.
- R11: Bit 0 of `own_addr` has no effect on address recognition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2c_scl_i | input | 1 | SCL line level |
| i2c_sda_i | input | 1 | SDA line level |
| i2c_scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| i2c_sda_pull | output | 1 | 1 pulls SDA low (ACK or data 0) |
| own_addr | input | 8 | Own address in bits [7:1]; bit 0 unused |
| ack_enable | input | 1 | Acknowledge enable; gates addressing and ends transfers |
| arb_lost | input | 1 | Pulse from the master side on arbitration loss |
| evt_valid | output | 1 | Status event pending |
| evt_ready | input | 1 | Host accepts the pending event |
| evt_code | output | 8 | Status code of the pending event, 0xF8 when none |
| rx_byte | output | 8 | Last address or data byte received |
| tx_byte | input | 8 | Next byte to send, sampled at the handshake in transmit |

## Verification
The assertions assume that `own_addr` only changes while no event is pending. They also assume that the bus master keeps SCL low for several clock cycles after each fall, so the synchronizer sees every edge. The bench meets both conditions. It writes the address only between transfers, and its bit-banged master holds each SCL half-period for eight cycles. It also waits for the line to rise before it counts the high phase. Host handshakes come only after the stretched 9th clock, or after a STOP, which keeps accepted events apart from fresh bus edges.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    S_FREE,
    S_ADDR,
    S_ADDR_ACK,
    S_RX,
    S_RX_ACK,
    S_TX_WAIT,
    S_TX,
    S_TX_ACK
  } slv_state_e;

  localparam logic [7:0] CODE_NONE        = 8'hF8;
  localparam logic [7:0] CODE_SR_ADDR     = 8'h60;
  localparam logic [7:0] CODE_SR_ADDR_ARB = 8'h68;
  localparam logic [7:0] CODE_SR_ACK      = 8'h80;
  localparam logic [7:0] CODE_SR_NACK     = 8'h88;
  localparam logic [7:0] CODE_SR_END      = 8'hA0;
  localparam logic [7:0] CODE_ST_ADDR     = 8'hA8;
  localparam logic [7:0] CODE_ST_ADDR_ARB = 8'hB0;
  localparam logic [7:0] CODE_ST_ACK      = 8'hB8;
  localparam logic [7:0] CODE_ST_NACK     = 8'hC0;
  localparam logic [7:0] CODE_ST_LAST     = 8'hC8;

  function automatic logic [7:0] addr_code(input logic rd, input logic arb);
    if (rd) return arb ? CODE_ST_ADDR_ARB : CODE_ST_ADDR;
    return arb ? CODE_SR_ADDR_ARB : CODE_SR_ADDR;
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int PIPE_W = STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe;
  logic [PIPE_W-1:0] sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
      sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_prev = scl_pipe[STAGES];
  assign sda_prev = sda_pipe[STAGES];

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2cs_stretch.sv
module i2cs_stretch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_pending,
  input  logic scl_s,
  output logic scl_pull
);

  // Engage only once SCL is seen low, then hold until the event is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_pull <= 1'b0;
    else        scl_pull <= evt_pending & (~scl_s | scl_pull);
  end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic [BYTE_BITS-1:0] own_addr,
  input  logic                 ack_enable,
  input  logic                 arb_lost,
  input  logic                 evt_ready,
  input  logic [BYTE_BITS-1:0] tx_byte,
  output logic                 evt_valid,
  output logic [7:0]           evt_code,
  output logic [BYTE_BITS-1:0] rx_byte,
  output logic                 sda_pull
);

  localparam int CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_BITS + 1);
  localparam logic [BYTE_BITS-1:0] ADDR_MASK = {{(BYTE_BITS-1){1'b1}}, 1'b0};

  slv_state_e           state;
  logic [CNT_W-1:0]     cnt;
  logic [BYTE_BITS-1:0] shreg;
  logic                 rd_q, ack_q, last_q, arb_q;
  logic                 valid_q, sda_q;
  logic [7:0]           code_q;
  logic [BYTE_BITS-1:0] rx_q;
  logic                 in_rx, addr_hit, take;

  assign in_rx    = (state == S_RX) || (state == S_RX_ACK);
  assign addr_hit = (((shreg ^ own_addr) & ADDR_MASK) == '0) && ack_enable;
  assign take     = valid_q && evt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_FREE;
      cnt     <= '0;
      shreg   <= '0;
      rd_q    <= 1'b0;
      ack_q   <= 1'b0;
      last_q  <= 1'b0;
      arb_q   <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= CODE_NONE;
      rx_q    <= '0;
      sda_q   <= 1'b0;
    end else begin
      if (arb_lost) arb_q <= 1'b1;
      if (take) begin
        valid_q <= 1'b0;
        code_q  <= CODE_NONE;
      end
      if (stop_det) begin
        if (in_rx) begin
          valid_q <= 1'b1;
          code_q  <= CODE_SR_END;
        end
        state <= S_FREE;
        sda_q <= 1'b0;
        arb_q <= 1'b0;
        cnt   <= '0;
      end else if (start_det) begin
        if (in_rx) begin
          valid_q <= 1'b1;
          code_q  <= CODE_SR_END;
        end
        state <= S_ADDR;
        sda_q <= 1'b0;
        cnt   <= '0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_BITS-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              if (addr_hit) begin
                sda_q <= 1'b1;
                rd_q  <= shreg[0];
                state <= S_ADDR_ACK;
              end else begin
                arb_q <= 1'b0;
                state <= S_FREE;
              end
            end
          end
          S_ADDR_ACK: begin
            if (scl_fall) begin
              sda_q   <= 1'b0;
              rx_q    <= shreg;
              valid_q <= 1'b1;
              code_q  <= addr_code(rd_q, arb_q);
              arb_q   <= 1'b0;
              cnt     <= '0;
              state   <= rd_q ? S_TX_WAIT : S_RX;
            end
          end
          S_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_BITS-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              ack_q <= ack_enable;
              sda_q <= ack_enable;
              state <= S_RX_ACK;
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              sda_q   <= 1'b0;
              rx_q    <= shreg;
              valid_q <= 1'b1;
              code_q  <= ack_q ? CODE_SR_ACK : CODE_SR_NACK;
              cnt     <= '0;
              state   <= ack_q ? S_RX : S_FREE;
            end
          end
          S_TX_WAIT: begin
            if (take) begin
              shreg  <= tx_byte;
              sda_q  <= ~tx_byte[BYTE_BITS-1];
              last_q <= ~ack_enable;
              cnt    <= '0;
              state  <= S_TX;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              sda_q <= 1'b0;
              state <= S_TX_ACK;
            end else if (scl_fall && cnt != '0) begin
              sda_q <= ~shreg[BYTE_BITS-2];
              shreg <= {shreg[BYTE_BITS-2:0], 1'b0};
            end
          end
          S_TX_ACK: begin
            if (scl_rise) begin
              ack_q <= ~sda_s;
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == ACK_BIT) begin
              valid_q <= 1'b1;
              code_q  <= !ack_q ? CODE_ST_NACK : (last_q ? CODE_ST_LAST : CODE_ST_ACK);
              cnt     <= '0;
              state   <= (ack_q && !last_q) ? S_TX_WAIT : S_FREE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign evt_valid = valid_q;
  assign evt_code  = code_q;
  assign rx_byte   = rx_q;
  assign sda_pull  = sda_q;

endmodule

// File: rtl/i2cs_responder.sv
module i2cs_responder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       i2c_scl_i,
  input  logic       i2c_sda_i,
  output logic       i2c_scl_pull,
  output logic       i2c_sda_pull,
  input  logic [7:0] own_addr,
  input  logic       ack_enable,
  input  logic       arb_lost,
  output logic       evt_valid,
  input  logic       evt_ready,
  output logic [7:0] evt_code,
  output logic [7:0] rx_byte,
  input  logic [7:0] tx_byte
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (i2c_scl_i),
    .sda_i     (i2c_sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .own_addr   (own_addr),
    .ack_enable (ack_enable),
    .arb_lost   (arb_lost),
    .evt_ready  (evt_ready),
    .tx_byte    (tx_byte),
    .evt_valid  (evt_valid),
    .evt_code   (evt_code),
    .rx_byte    (rx_byte),
    .sda_pull   (i2c_sda_pull)
  );

  i2cs_stretch u_stretch (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pending (evt_valid),
    .scl_s       (scl_s),
    .scl_pull    (i2c_scl_pull)
  );

endmodule

// File: rtl/i2cs_responder_chk.sv
module i2cs_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic       evt_ready,
  input logic [7:0] evt_code,
  input logic [7:0] rx_byte,
  input logic [7:0] own_addr,
  input logic       i2c_scl_pull
);

  assert_hold_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_code) && $stable(rx_byte));

  assert_take_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ready |=> !evt_valid);

  assert_no_stretch_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> !i2c_scl_pull);

  assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> evt_code == 8'hF8);

  assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code inside {8'h60, 8'h68, 8'h80, 8'h88, 8'hA0,
                                    8'hA8, 8'hB0, 8'hB8, 8'hC0, 8'hC8}));

  assert_addr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && (evt_code inside {8'h60, 8'h68, 8'hA8, 8'hB0})
      |-> rx_byte[7:1] == own_addr[7:1]);

endmodule

bind i2cs_responder i2cs_responder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_valid    (evt_valid),
  .evt_ready    (evt_ready),
  .evt_code     (evt_code),
  .rx_byte      (rx_byte),
  .own_addr     (own_addr),
  .i2c_scl_pull (i2c_scl_pull)
);

// File: tb/i2cs_responder_test.sv
module i2cs_responder_test;

  localparam int H = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, m_scl_low, m_sda_low;
  logic       scl_line, sda_line, scl_pull, sda_pull;
  logic [7:0] own_addr, tx_byte, evt_code, rx_byte;
  logic       ack_enable, arb_lost, evt_valid, evt_ready;

  int n_chk = 0;
  int n_fail = 0;

  assign scl_line = !(m_scl_low || scl_pull);
  assign sda_line = !(m_sda_low || sda_pull);

  i2cs_responder uut (
    .clk(clk), .rst_n(rst_n), .i2c_scl_i(scl_line), .i2c_sda_i(sda_line),
    .i2c_scl_pull(scl_pull), .i2c_sda_pull(sda_pull), .own_addr(own_addr),
    .ack_enable(ack_enable), .arb_lost(arb_lost), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_code(evt_code), .rx_byte(rx_byte), .tx_byte(tx_byte)
  );

  function automatic logic [7:0] exp_addr(input bit rd, input bit arb);
    if (rd) return arb ? 8'hB0 : 8'hA8;
    return arb ? 8'h68 : 8'h60;
  endfunction
  function automatic logic [7:0] exp_rx(input bit ack);
    return ack ? 8'h80 : 8'h88;
  endfunction
  function automatic logic [7:0] exp_tx(input bit mack, input bit last);
    if (!mack) return 8'hC0;
    return last ? 8'hC8 : 8'hB8;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic clk_bit(input bit drive_low, output bit sampled);
    m_sda_low = drive_low;
    half();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    half();
    sampled = sda_line;
    m_scl_low = 1'b1;
    half();
  endtask

  task automatic m_start();
    m_sda_low = 1'b0;
    half();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    half();
    m_sda_low = 1'b1;
    half();
    m_scl_low = 1'b1;
    half();
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1;
    half();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    half();
    m_sda_low = 1'b0;
    half();
  endtask

  task automatic write_byte(input logic [7:0] b, output bit nak);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(!b[i], s);
    clk_bit(1'b0, nak);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, s);
      b[i] = s;
    end
    clk_bit(mack, s);
  endtask

  task automatic svc(input logic [7:0] exp, input string req, input bit stretched);
    check(evt_valid == 1'b1, req, evt_valid, 1);
    check(evt_code == exp, req, evt_code, exp);
    check(scl_pull == stretched, {req, " R10 stretch"}, scl_pull, stretched);
    evt_ready = 1'b1;
    @(negedge clk);
    evt_ready = 1'b0;
    repeat (2) @(negedge clk);
    check(!evt_valid && evt_code == 8'hF8, "R10 after handshake", evt_code, 8'hF8);
  endtask

  task automatic pulse_arb();
    arb_lost = 1'b1;
    @(negedge clk);
    arb_lost = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a, input int nbytes, input bit arb);
    bit nak, alive, ae;
    logic [7:0] d;
    m_start();
    if (arb) pulse_arb();
    write_byte({a, 1'b0}, nak);
    check(nak == 1'b0, "R2 address ACK", nak, 0);
    svc(exp_addr(1'b0, arb), arb ? "R9 write code" : "R2 write code", 1'b1);
    check(rx_byte == {a, 1'b0}, "R2 rx_byte address", rx_byte, {a, 1'b0});
    alive = 1'b1;
    for (int i = 0; i < nbytes; i++) begin
      d = 8'($urandom);
      ae = ($urandom % 4) != 0;
      ack_enable = ae;
      write_byte(d, nak);
      if (alive) begin
        check(nak == !ae, "R5 data ack bit", nak, !ae);
        svc(exp_rx(ae), "R5 data code", 1'b1);
        check(rx_byte == d, "R5 rx_byte data", rx_byte, d);
        if (!ae) alive = 1'b0;
      end else begin
        check(nak == 1'b1 && !evt_valid, "R5 ignored after NACK", nak, 1);
      end
    end
    ack_enable = 1'b1;
    m_stop();
    repeat (4) @(negedge clk);
    if (alive) svc(8'hA0, "R8 stop code", 1'b0);
    else check(!evt_valid, "R5 no stop event", evt_valid, 0);
  endtask

  task automatic do_read(input logic [6:0] a, input int nbytes, input bit arb);
    bit nak, mode_last, mack, last;
    logic [7:0] tx, got;
    mode_last = $urandom % 2;
    m_start();
    if (arb) pulse_arb();
    write_byte({a, 1'b1}, nak);
    check(nak == 1'b0, "R3 address ACK", nak, 0);
    tx = 8'($urandom);
    tx_byte = tx;
    last = (nbytes == 1) && mode_last;
    ack_enable = !last;
    svc(exp_addr(1'b1, arb), arb ? "R9 read code" : "R3 read code", 1'b1);
    check(rx_byte == {a, 1'b1}, "R3 rx_byte address", rx_byte, {a, 1'b1});
    for (int i = 0; i < nbytes; i++) begin
      mack = (i < nbytes - 1) || mode_last;
      read_byte(mack, got);
      check(got == tx, "R3 sent byte", got, tx);
      if (i < nbytes - 1) begin
        tx = 8'($urandom);
        tx_byte = tx;
        last = (i + 1 == nbytes - 1) && mode_last;
        ack_enable = !last;
        svc(exp_tx(mack, 1'b0), "R6 ack code", 1'b1);
      end else begin
        svc(exp_tx(mack, last), mode_last ? "R7 last code" : "R6 nack code", 1'b1);
      end
    end
    ack_enable = 1'b1;
    if (mode_last) begin
      read_byte(1'b0, got);
      check(got == 8'hFF, "R7 released reads ones", got, 8'hFF);
      check(!evt_valid, "R7 no event after release", evt_valid, 0);
    end
    check(sda_pull == 1'b0, "R6 SDA released", sda_pull, 0);
    m_stop();
    repeat (4) @(negedge clk);
    check(!evt_valid, "R6 no stop event in transmit", evt_valid, 0);
  endtask

  task automatic do_ignored(input logic [7:0] first);
    bit nak;
    logic [7:0] d;
    m_start();
    write_byte(first, nak);
    check(nak == 1'b1, "R4 no ACK", nak, 1);
    check(!evt_valid, "R4 no event", evt_valid, 0);
    d = 8'($urandom);
    write_byte(d, nak);
    check(nak == 1'b1 && !evt_valid, "R4 data ignored", nak, 1);
    m_stop();
    repeat (4) @(negedge clk);
    check(!evt_valid, "R4 no stop event", evt_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: got hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [6:0] a;
    logic [7:0] got;
    bit nak;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0;
    own_addr = 8'h00; ack_enable = 1'b1; arb_lost = 1'b0;
    evt_ready = 1'b0; tx_byte = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!evt_valid, "R1 evt_valid", evt_valid, 0);
    check(evt_code == 8'hF8, "R1 evt_code", evt_code, 8'hF8);
    check(!scl_pull && !sda_pull, "R1 line pulls", {scl_pull, sda_pull}, 0);

    a = 7'h2D;
    own_addr = {a, 1'b1};
    do_write(a, 2, 1'b0);
    do_read(a, 2, 1'b0);
    do_write(a, 1, 1'b1);
    do_read(a, 1, 1'b1);
    do_ignored({a ^ 7'h01, 1'b0});
    ack_enable = 1'b0;
    do_ignored({a, 1'b0});
    ack_enable = 1'b1;

    // R8 repeated START while receiving, then read back
    m_start();
    write_byte({a, 1'b0}, nak);
    svc(8'h60, "R8 setup address", 1'b1);
    write_byte(8'h3C, nak);
    svc(8'h80, "R8 setup data", 1'b1);
    m_start();
    repeat (2) @(negedge clk);
    svc(8'hA0, "R8 repeated start code", 1'b1);
    write_byte({a, 1'b1}, nak);
    check(nak == 1'b0, "R8 address after repeated start", nak, 0);
    tx_byte = 8'h96;
    svc(8'hA8, "R8 read after repeated start", 1'b1);
    read_byte(1'b0, got);
    check(got == 8'h96, "R8 byte after repeated start", got, 8'h96);
    svc(8'hC0, "R6 nack after repeated start", 1'b1);
    m_stop();
    repeat (4) @(negedge clk);

    for (int it = 0; it < 20; it++) begin
      int kind;
      a = 7'($urandom);
      own_addr = {a, 1'($urandom)};  // R11 bit 0 random
      kind = $urandom % 4;
      case (kind)
        0: do_write(a, 1 + $urandom % 3, ($urandom % 4) == 0);
        1: do_read(a, 1 + $urandom % 3, ($urandom % 4) == 0);
        2: do_ignored({a ^ 7'(1 + $urandom % 127), 1'($urandom)});
        default: begin
          ack_enable = 1'b0;
          do_ignored({a, 1'($urandom)});
          ack_enable = 1'b1;
        end
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule